// File: doc/BRIEF.md
# Block-Transfer DMA Launch Controller

This block runs a master block-transfer DMA toward a parallel backplane bus. Software sets it up through a small byte-wide write port: a 16-bit byte count split over a low and a high byte register, a mode register whose wide-data flag selects 8-byte beats, a control register with enable, direction and completion-interrupt enable, and a vector register that supplies the interrupt vector.

Once enable is set, the transfer begins when software writes into the mapped target window; the data of that write is the local start address. The engine then issues one beat request per data beat on a simple request/acknowledge handshake, stepping the local address and counting the remaining bytes down. Arbitration and the physical bus timing sit behind that handshake. The address modifier taken from the mapping entry at launch is turned into its block-mode code, while user-defined codes pass through untouched. When the count runs out, an interrupt carrying the programmed vector is raised if enabled.

Top module: `btd_launch_ctrl`

## Requirements
- R1: After reset, busy, beat_req, irq and err are all low.
- R2: The byte count is the low byte at register offset 0 and the high byte at offset 1; a transfer issues ceil(count / step) beats, where step is the beat width in bytes.
- R3: Bit 4 of the mode register at offset 2 selects 8-byte beats (beat_wide high, address advances by 8 per accepted beat); with it clear the beat is 4 bytes and the address advances by 4.
- R4: The control register at offset 3 holds enable in bit 0, direction in bit 1 (1 = local memory to bus) and interrupt enable in bit 2; a window write with enable set starts a transfer whose first beat_addr is the window write data and whose beat_dir equals bit 1.
- R5: Clearing enable while a transfer runs does not stop it; all its beats are still issued.
- R6: With interrupt enable set, irq rises at the clock edge where busy falls, irq_vec equals the vector register (offset 4) at that moment, and irq stays high until irq_ack; with interrupt enable clear, irq stays low.
- R7: beat_am is the mapped modifier latched at launch: 0x09 becomes 0x0B, 0x0D becomes 0x0F, 0x39 becomes 0x3B, 0x3D becomes 0x3F; user-defined codes 0x10 to 0x1F and every other code pass unchanged.
- R8: A launch with a count of zero never raises busy or beat_req and raises irq (if enabled) at the launch edge.
- R9: A window write while enable is clear or while busy is ignored (no start, the running address sequence is unchanged) and sets err, which stays high until reset.
- R10: The address and remaining count advance only on a clock edge where beat_ack is high; while beat_ack is low, beat_addr holds and busy stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| win_we | input | 1 | Write into the mapped target window (launch trigger) |
| win_data | input | ADDR_W | Window write data, taken as the local start address |
| map_am | input | 6 | Address modifier from the mapping entry |
| beat_req | output | 1 | Beat request toward the bus side |
| beat_ack | input | 1 | Beat accepted |
| beat_addr | output | ADDR_W | Local address of the current beat |
| beat_dir | output | 1 | Direction of the transfer (1 = local to bus) |
| beat_wide | output | 1 | 8-byte beats when high, 4-byte beats when low |
| beat_am | output | 6 | Block-mode address modifier |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt |
| irq_ack | input | 1 | Clears irq |
| irq_vec | output | 8 | Vector presented with irq |
| err | output | 1 | Sticky rejected-launch status |

## Verification
The hardest state to reach is a second window write landing while a transfer is already running, because it must be ignored without disturbing the address sequence in flight. The stimulus holds beat_ack low right after a launch, so the engine stays busy for as long as needed, then issues the rogue window write with a different address and also clears enable mid-transfer before releasing the acknowledge and counting every beat address from the original start. A table of length, width and modifier combinations covers beat counts with partial last beats, a count using the high byte, and every mapping class.

// File: rtl/btd_pkg.sv
package btd_pkg;

  localparam int REG_AW = 3;
  localparam int REG_DW = 8;
  localparam int LEN_W  = 2 * REG_DW;
  localparam int AM_W   = 6;
  localparam int STEP_W = 4;

  localparam int MODE_WIDE_BIT = 4;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_DIR_BIT  = 1;
  localparam int CTRL_IE_BIT   = 2;

  typedef enum logic [REG_AW-1:0] {
    SEL_CNT_LO = 3'd0,
    SEL_CNT_HI = 3'd1,
    SEL_MODE   = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_VEC    = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic              wide;
    logic              en;
    logic              dir;
    logic              ie;
    logic [REG_DW-1:0] vec;
  } cfg_t;

  // user-defined modifier range
  function automatic logic am_is_user(input logic [AM_W-1:0] am);
    return (am >= 6'h10) && (am <= 6'h1F);
  endfunction

  // block-mode form of a modifier code
  function automatic logic [AM_W-1:0] am_block_form(input logic [AM_W-1:0] am);
    logic [AM_W-1:0] r;
    r = am;
    if (!am_is_user(am)) begin
      case (am)
        6'h09:   r = 6'h0B;
        6'h0D:   r = 6'h0F;
        6'h39:   r = 6'h3B;
        6'h3D:   r = 6'h3F;
        default: r = am;
      endcase
    end
    return r;
  endfunction

  // bytes moved per beat
  function automatic logic [STEP_W-1:0] beat_step(input logic wide);
    return wide ? 4'd8 : 4'd4;
  endfunction

endpackage

// File: rtl/btd_regs.sv
module btd_regs
  import btd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output cfg_t              cfg_o
);

  logic [REG_DW-1:0] cnt_lo_q, cnt_hi_q, vec_q;
  logic              wide_q, en_q, dir_q, ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
      vec_q    <= '0;
      wide_q   <= 1'b0;
      en_q     <= 1'b0;
      dir_q    <= 1'b0;
      ie_q     <= 1'b0;
    end else if (we_i) begin
      case (reg_sel_e'(addr_i))
        SEL_CNT_LO: cnt_lo_q <= wdata_i;
        SEL_CNT_HI: cnt_hi_q <= wdata_i;
        SEL_MODE:   wide_q   <= wdata_i[MODE_WIDE_BIT];
        SEL_CTRL: begin
          en_q  <= wdata_i[CTRL_EN_BIT];
          dir_q <= wdata_i[CTRL_DIR_BIT];
          ie_q  <= wdata_i[CTRL_IE_BIT];
        end
        SEL_VEC:    vec_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_o.len  = {cnt_hi_q, cnt_lo_q};
    cfg_o.wide = wide_q;
    cfg_o.en   = en_q;
    cfg_o.dir  = dir_q;
    cfg_o.ie   = ie_q;
    cfg_o.vec  = vec_q;
  end

endmodule

// File: rtl/btd_am_map.sv
module btd_am_map
  import btd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AM_W-1:0] am_i,
  output logic [AM_W-1:0] am_o
);

  assign am_o = am_block_form(am_i);

  AST_AM_NO_PLAIN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(am_o inside {6'h09, 6'h0D, 6'h39, 6'h3D}))
    else $error("plain data modifier escaped mapping"); // R7

  AST_AM_USER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (am_i[5:4] == 2'b01) |-> (am_o == am_i))
    else $error("user modifier altered"); // R7

endmodule

// File: rtl/btd_engine.sv
module btd_engine
  import btd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg_i,
  input  logic              win_we_i,
  input  logic [ADDR_W-1:0] win_data_i,
  input  logic [AM_W-1:0]   am_blk_i,
  input  logic              beat_ack_i,
  input  logic              irq_ack_i,
  output logic              beat_req_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              beat_dir_o,
  output logic              beat_wide_o,
  output logic [AM_W-1:0]   beat_am_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic [REG_DW-1:0] irq_vec_o,
  output logic              err_o
);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              wide_q, dir_q, irq_q, err_q;
  logic [AM_W-1:0]   am_q;
  logic [REG_DW-1:0] vec_q;

  // named internal events
  logic             launch_evt, reject_evt, beat_fire, last_beat, done_evt, zero_len;
  logic [LEN_W-1:0] step_len;

  assign step_len   = LEN_W'(beat_step(wide_q));
  assign zero_len   = (cfg_i.len == '0);
  assign launch_evt = win_we_i && cfg_i.en && (st_q == ST_IDLE);
  assign reject_evt = win_we_i && !launch_evt;
  assign beat_fire  = (st_q == ST_RUN) && beat_ack_i;
  assign last_beat  = (rem_q <= step_len);
  assign done_evt   = (beat_fire && last_beat) || (launch_evt && zero_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      wide_q <= 1'b0;
      dir_q  <= 1'b0;
      am_q   <= '0;
    end else if (launch_evt) begin
      addr_q <= win_data_i;
      rem_q  <= cfg_i.len;
      wide_q <= cfg_i.wide;
      dir_q  <= cfg_i.dir;
      am_q   <= am_blk_i;
      st_q   <= zero_len ? ST_IDLE : ST_RUN;
    end else if (beat_fire) begin
      addr_q <= addr_q + ADDR_W'(beat_step(wide_q));
      rem_q  <= last_beat ? '0 : rem_q - step_len;
      if (last_beat) st_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (reject_evt) err_q <= 1'b1;
      if (done_evt && cfg_i.ie) begin
        irq_q <= 1'b1;
        vec_q <= cfg_i.vec;
      end else if (irq_ack_i) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign busy_o      = (st_q == ST_RUN);
  assign beat_req_o  = busy_o;
  assign beat_addr_o = addr_q;
  assign beat_dir_o  = dir_q;
  assign beat_wide_o = wide_q;
  assign beat_am_o   = am_q;
  assign irq_o       = irq_q;
  assign irq_vec_o   = vec_q;
  assign err_o       = err_q;

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(win_we_i && cfg_i.en))
    else $error("start without enabled window write"); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && beat_ack_i && !last_beat) |=>
      (beat_addr_o == $past(beat_addr_o) + ($past(beat_wide_o) ? ADDR_W'(8) : ADDR_W'(4))))
    else $error("address step wrong"); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !beat_ack_i) |=> (busy_o && $stable(beat_addr_o)))
    else $error("advanced without ack"); // R10

  AST_EN_DROP_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cfg_i.en && !(beat_ack_i && last_beat)) |=> busy_o)
    else $error("transfer stopped by enable clear"); // R5

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_evt && zero_len) |=> !busy_o)
    else $error("zero length went busy"); // R8

  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && cfg_i.ie) |=> irq_o)
    else $error("missing completion interrupt"); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o)
    else $error("error status dropped"); // R9

endmodule

// File: rtl/btd_launch_ctrl.sv
module btd_launch_ctrl
  import btd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              win_we,
  input  logic [ADDR_W-1:0] win_data,
  input  logic [5:0]        map_am,
  output logic              beat_req,
  input  logic              beat_ack,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_dir,
  output logic              beat_wide,
  output logic [5:0]        beat_am,
  output logic              busy,
  output logic              irq,
  input  logic              irq_ack,
  output logic [7:0]        irq_vec,
  output logic              err
);

  cfg_t            cfg;
  logic [AM_W-1:0] am_blk;

  btd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .cfg_o   (cfg)
  );

  btd_am_map u_am (
    .clk   (clk),
    .rst_n (rst_n),
    .am_i  (map_am),
    .am_o  (am_blk)
  );

  btd_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (cfg),
    .win_we_i    (win_we),
    .win_data_i  (win_data),
    .am_blk_i    (am_blk),
    .beat_ack_i  (beat_ack),
    .irq_ack_i   (irq_ack),
    .beat_req_o  (beat_req),
    .beat_addr_o (beat_addr),
    .beat_dir_o  (beat_dir),
    .beat_wide_o (beat_wide),
    .beat_am_o   (beat_am),
    .busy_o      (busy),
    .irq_o       (irq),
    .irq_vec_o   (irq_vec),
    .err_o       (err)
  );

endmodule

// File: tb/tb_btd_launch_ctrl.sv
module tb_btd_launch_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        win_we = 1'b0;
  logic [31:0] win_data = '0;
  logic [5:0]  map_am = '0;
  logic        beat_req, beat_dir, beat_wide, busy, irq, err;
  logic        beat_ack = 1'b0;
  logic        irq_ack = 1'b0;
  logic [31:0] beat_addr;
  logic [5:0]  beat_am;
  logic [7:0]  irq_vec;

  int checks = 0;
  int fails  = 0;

  btd_launch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .win_we(win_we), .win_data(win_data),
    .map_am(map_am), .beat_req(beat_req), .beat_ack(beat_ack),
    .beat_addr(beat_addr), .beat_dir(beat_dir), .beat_wide(beat_wide),
    .beat_am(beat_am), .busy(busy), .irq(irq), .irq_ack(irq_ack),
    .irq_vec(irq_vec), .err(err)
  );

  always #10 clk = ~clk;

  // len16 | wide1 | am6 | exp_am6 | beats8
  localparam int NV = 8;
  localparam logic [36:0] VECS [NV] = '{
    {16'd16,  1'b0, 6'h09, 6'h0B, 8'd4},
    {16'd16,  1'b1, 6'h0D, 6'h0F, 8'd2},
    {16'd10,  1'b0, 6'h39, 6'h3B, 8'd3},
    {16'd10,  1'b1, 6'h3D, 6'h3F, 8'd2},
    {16'd4,   1'b0, 6'h15, 6'h15, 8'd1},
    {16'd8,   1'b1, 6'h1F, 6'h1F, 8'd1},
    {16'd300, 1'b1, 6'h10, 6'h10, 8'd38},
    {16'd3,   1'b0, 6'h29, 6'h29, 8'd1}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic launch(input logic [31:0] a);
    win_we = 1'b1; win_data = a;
    @(negedge clk);
    win_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; beat_ack = 1'b0; irq_ack = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ack_irq();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // acknowledge every beat, count them and compare addresses
  task automatic run_beats(input logic [31:0] start, input int step,
                           output int n, output bit addr_ok);
    n = 0; addr_ok = 1'b1;
    beat_ack = 1'b1;
    while (busy && n < 400) begin
      if (!beat_req || beat_addr !== start + 32'(n * step)) addr_ok = 1'b0;
      n++;
      @(negedge clk);
    end
    beat_ack = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit ok;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check(busy == 0,     "R1 busy",     busy, 0);
    check(beat_req == 0, "R1 beat_req", beat_req, 0);
    check(irq == 0,      "R1 irq",      irq, 0);
    check(err == 0,      "R1 err",      err, 0);

    // table walk: R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [15:0] len;
      logic        wide;
      logic [5:0]  am, exp_am;
      logic [7:0]  exp_beats;
      logic [31:0] start;
      logic        dir;
      {len, wide, am, exp_am, exp_beats} = VECS[i];
      start = 32'h1000_0000 + 32'(i) * 32'h100;
      dir = i[0];
      wr(3'd0, len[7:0]);
      wr(3'd1, len[15:8]);
      wr(3'd2, {3'b000, wide, 4'b0000});
      wr(3'd4, 8'hA0 + 8'(i));
      wr(3'd3, {5'b0, 1'b1, dir, 1'b1});
      map_am = am;
      launch(start);
      check(beat_am == exp_am, "R7 mapped modifier", beat_am, exp_am);
      check(beat_dir == dir,   "R4 direction",       beat_dir, dir);
      check(beat_wide == wide, "R3 beat width flag", beat_wide, wide);
      run_beats(start, wide ? 8 : 4, n, ok);
      check(n == int'(exp_beats), "R2 beat count", n, exp_beats);
      check(ok, "R3 address sequence", ok, 1);
      check(irq == 1, "R6 irq at completion", irq, 1);
      check(irq_vec == 8'hA0 + 8'(i), "R6 vector", irq_vec, 8'hA0 + 8'(i));
      @(negedge clk);
      check(irq == 1, "R6 irq held", irq, 1);
      ack_irq();
      check(irq == 0, "R6 irq cleared by ack", irq, 0);
    end
    check(err == 0, "R9 no error after valid launches", err, 0);

    // R6 interrupt disabled
    wr(3'd0, 8'd8); wr(3'd1, 8'd0); wr(3'd2, 8'h00);
    wr(3'd3, 8'h01);
    launch(32'h2000);
    run_beats(32'h2000, 4, n, ok);
    check(n == 2, "R2 beats with irq off", n, 2);
    check(irq == 0, "R6 no irq when disabled", irq, 0);

    // R8 zero length
    wr(3'd0, 8'd0); wr(3'd1, 8'd0); wr(3'd4, 8'h5C); wr(3'd3, 8'h05);
    launch(32'h3000);
    check(busy == 0,     "R8 zero length not busy", busy, 0);
    check(beat_req == 0, "R8 zero length no beat",  beat_req, 0);
    check(irq == 1,      "R8 zero length irq",      irq, 1);
    check(irq_vec == 8'h5C, "R8 zero length vector", irq_vec, 8'h5C);
    @(negedge clk);
    check(beat_req == 0, "R8 still no beat", beat_req, 0);
    ack_irq();

    // R9 launch with enable clear
    do_reset();
    wr(3'd0, 8'd16); wr(3'd3, 8'h04);
    launch(32'h4000);
    check(busy == 0, "R9 disabled launch ignored", busy, 0);
    check(err == 1,  "R9 error set",               err, 1);

    // R5 R9 R10 stall, enable clear and rogue launch while busy
    do_reset();
    wr(3'd0, 8'd16); wr(3'd3, 8'h05);
    launch(32'h5000);
    wr(3'd3, 8'h04);               // clear enable mid-transfer
    launch(32'h9990);              // rogue launch while busy
    @(negedge clk);
    check(busy == 1, "R10 held while stalled", busy, 1);
    check(beat_addr == 32'h5000, "R10 address held", beat_addr, 32'h5000);
    check(err == 1, "R9 busy launch flagged", err, 1);
    run_beats(32'h5000, 4, n, ok);
    check(n == 4, "R5 all beats after enable clear", n, 4);
    check(ok, "R9 sequence unaffected by rogue launch", ok, 1);
    check(irq == 1, "R5 completion irq", irq, 1);
    @(negedge clk);
    check(err == 1, "R9 error sticky", err, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule